// File: doc/BRIEF.md
# Device Power State Controller

This block keeps the committed power state of a wireless network device and moves it toward a state the host asks for. The host presents a target state on a valid/ready request port. The controller checks that the target can be reached. It then breaks the move into single hops along the legal transition graph. For each hop it asks a downstream sequence engine to run one step by sending a step-select code with a start pulse. It commits the new state only after the engine answers with done.

Card emulation is the hub of the graph. Active, suspend and power-down each connect only to card emulation. Low-power connects only to active. Power-off is left once, toward card emulation, and is never entered again. A move such as active to power-down therefore takes two engine steps, and low-power to suspend takes three. Only one request is handled at a time. If the engine reports an error, the chain stops at the last committed state and an error flag is raised.

Top module: `pwr_state_ctrl`

## Requirements
- R1: State encoding is 0 power-off, 1 power-down, 2 card emulation, 3 active, 4 low-power, 5 suspend. After reset, curState is 0, reqReady is 1, seqStart is 0 and errFlag is 0. Once left, state 0 is never entered again.
- R2: While in power-off, only target 2 is accepted (step code 0). Every other target is rejected.
- R3: Each hop drives one step code. The codes are: off→emu 0, emu→active 1, active→emu 2, emu→suspend 3, suspend→emu 4, emu→down 5, down→emu 6, active→low 7, low→active 8.
- R4: Composite targets follow the only path through the graph, one hop per engine step. Examples: active→down issues 2 then 5, active→suspend issues 2 then 3, low→down issues 8, 2 then 5.
- R5: seqStart is a one-cycle pulse. It is high in the cycle after the edge that accepts the request, and in the cycle after the edge that commits a non-final hop. seqCode is valid while seqStart is high.
- R6: curState changes only on the edge that samples seqDone high while the controller waits for the current step. Before that edge it holds the previous state.
- R7: reqReady is low from the edge that accepts a legal request until the chain ends. A request presented while reqReady is low has no effect.
- R8: A target of 0, 6, 7, the current state, or one not allowed by R2 is rejected. On the accepting edge errFlag is set, the state does not change, no seqStart follows, and reqReady stays high.
- R9: If seqErr is sampled while waiting, the chain stops. curState keeps the last committed state, errFlag is set, and reqReady returns high on the same edge.
- R10: errFlag stays high until the next legal request is accepted, which clears it.
- R11: seqDone outside the waiting phase (while idle or during the start cycle) is ignored.
- R12: If seqDone and seqErr are both high while waiting, the error wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqTarget | input | 3 | Requested target state |
| reqReady | output | 1 | Controller idle, request can be taken |
| seqStart | output | 1 | One-cycle start of an engine step |
| seqCode | output | 4 | Step-select code for the engine |
| seqDone | input | 1 | Engine finished the step |
| seqErr | input | 1 | Engine failed the step |
| curState | output | 3 | Committed power state |
| errFlag | output | 1 | Last request was rejected or failed |

## Verification
A wrong routing decision shows up at the first seqStart of the chain, as an unexpected seqCode, one cycle after acceptance. A wrongly committed state appears on curState on the edge after the engine's done, or as a hop code that does not start from the committed state. A phase error in the controller is visible within one cycle in several ways: a missing or doubled start pulse, reqReady high during a chain, or a done taken during the start cycle. Each of these is checked hop by hop for every start state and every target code, including error injection at each step of the longest chains.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  localparam int STATE_W = 3;
  localparam int CODE_W  = 4;
  localparam int NUM_STATES = 6;

  typedef enum logic [STATE_W-1:0] {
    PS_OFF    = 3'd0,
    PS_DOWN   = 3'd1,
    PS_EMU    = 3'd2,
    PS_ACTIVE = 3'd3,
    PS_LOW    = 3'd4,
    PS_SLEEP  = 3'd5
  } pwrState_t;

  // step-select codes understood by the sequence engine
  localparam logic [CODE_W-1:0] SEQ_POWER_ON     = 4'd0;
  localparam logic [CODE_W-1:0] SEQ_EMU_TO_ACT   = 4'd1;
  localparam logic [CODE_W-1:0] SEQ_ACT_TO_EMU   = 4'd2;
  localparam logic [CODE_W-1:0] SEQ_EMU_TO_SLEEP = 4'd3;
  localparam logic [CODE_W-1:0] SEQ_SLEEP_TO_EMU = 4'd4;
  localparam logic [CODE_W-1:0] SEQ_EMU_TO_DOWN  = 4'd5;
  localparam logic [CODE_W-1:0] SEQ_DOWN_TO_EMU  = 4'd6;
  localparam logic [CODE_W-1:0] SEQ_ACT_TO_LOW   = 4'd7;
  localparam logic [CODE_W-1:0] SEQ_LOW_TO_ACT   = 4'd8;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic acceptReq;
    logic rejectReq;
    logic commitStep;
    logic failStep;
  } ctrlStrobe_t;

  // next state on the way from 'from' to 'goal' (graph is a tree rooted at EMU)
  function automatic pwrState_t routeHop(pwrState_t from, pwrState_t goal);
    pwrState_t hop;
    case (from)
      PS_LOW:    hop = PS_ACTIVE;
      PS_ACTIVE: hop = (goal == PS_LOW) ? PS_LOW : PS_EMU;
      PS_EMU:    hop = (goal == PS_LOW || goal == PS_ACTIVE) ? PS_ACTIVE : goal;
      default:   hop = PS_EMU;
    endcase
    return hop;
  endfunction

  function automatic logic [CODE_W-1:0] stepCodeOf(pwrState_t from, pwrState_t to);
    logic [CODE_W-1:0] code;
    case ({from, to})
      {PS_EMU,    PS_ACTIVE}: code = SEQ_EMU_TO_ACT;
      {PS_ACTIVE, PS_EMU}:    code = SEQ_ACT_TO_EMU;
      {PS_EMU,    PS_SLEEP}:  code = SEQ_EMU_TO_SLEEP;
      {PS_SLEEP,  PS_EMU}:    code = SEQ_SLEEP_TO_EMU;
      {PS_EMU,    PS_DOWN}:   code = SEQ_EMU_TO_DOWN;
      {PS_DOWN,   PS_EMU}:    code = SEQ_DOWN_TO_EMU;
      {PS_ACTIVE, PS_LOW}:    code = SEQ_ACT_TO_LOW;
      {PS_LOW,    PS_ACTIVE}: code = SEQ_LOW_TO_ACT;
      default:                code = SEQ_POWER_ON;
    endcase
    return code;
  endfunction

  function automatic logic isReachable(pwrState_t from, logic [STATE_W-1:0] goal);
    logic inRange;
    inRange = (goal != 3'd0) && (int'(goal) < NUM_STATES);
    return inRange && (goal != from) && (from != PS_OFF || goal == PS_EMU);
  endfunction

endpackage

// File: rtl/pwr_route_dp.sv
module pwr_route_dp
  import pwr_state_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [STATE_W-1:0]  reqTarget,
  output logic                reqLegal,
  output logic                hopIsLast,
  output logic [CODE_W-1:0]   stepCode,
  output logic [STATE_W-1:0]  curState,
  output logic                errFlag
);

  pwrState_t curQ;
  pwrState_t goalQ;
  pwrState_t hopState;
  logic      errQ;

  always_comb begin
    reqLegal  = isReachable(curQ, reqTarget);
    hopState  = routeHop(curQ, goalQ);
    hopIsLast = (hopState == goalQ);
    stepCode  = stepCodeOf(curQ, hopState);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ  <= PS_OFF;
      goalQ <= PS_EMU;
      errQ  <= 1'b0;
    end else begin
      if (strobe.acceptReq) begin
        goalQ <= pwrState_t'(reqTarget);
        errQ  <= 1'b0;
      end
      if (strobe.rejectReq || strobe.failStep) begin
        errQ <= 1'b1;
      end
      if (strobe.commitStep) begin
        curQ <= hopState;
      end
    end
  end

  assign curState = curQ;
  assign errFlag  = errQ;

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_state_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqLegal,
  input  logic        hopIsLast,
  input  logic        seqDone,
  input  logic        seqErr,
  output logic        reqReady,
  output logic        seqStart,
  output ctrlStrobe_t strobe
);

  typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT} phase_t;

  phase_t phaseQ, phaseD;

  always_comb begin
    strobe.acceptReq  = (phaseQ == PH_IDLE) && reqValid && reqLegal;
    strobe.rejectReq  = (phaseQ == PH_IDLE) && reqValid && !reqLegal;
    strobe.failStep   = (phaseQ == PH_WAIT) && seqErr;
    strobe.commitStep = (phaseQ == PH_WAIT) && seqDone && !seqErr;

    phaseD = phaseQ;
    case (phaseQ)
      PH_IDLE:  if (strobe.acceptReq) phaseD = PH_ISSUE;
      PH_ISSUE: phaseD = PH_WAIT;
      PH_WAIT: begin
        if (strobe.failStep)        phaseD = PH_IDLE;
        else if (strobe.commitStep) phaseD = hopIsLast ? PH_IDLE : PH_ISSUE;
      end
      default:  phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= PH_IDLE;
    else       phaseQ <= phaseD;
  end

  assign reqReady = (phaseQ == PH_IDLE);
  assign seqStart = (phaseQ == PH_ISSUE);

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [STATE_W-1:0] reqTarget,
  output logic               reqReady,
  output logic               seqStart,
  output logic [CODE_W-1:0]  seqCode,
  input  logic               seqDone,
  input  logic               seqErr,
  output logic [STATE_W-1:0] curState,
  output logic               errFlag
);

  ctrlStrobe_t strobe;
  logic        reqLegal;
  logic        hopIsLast;

  pwr_seq_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqLegal  (reqLegal),
    .hopIsLast (hopIsLast),
    .seqDone   (seqDone),
    .seqErr    (seqErr),
    .reqReady  (reqReady),
    .seqStart  (seqStart),
    .strobe    (strobe)
  );

  pwr_route_dp i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqTarget (reqTarget),
    .reqLegal  (reqLegal),
    .hopIsLast (hopIsLast),
    .stepCode  (seqCode),
    .curState  (curState),
    .errFlag   (errFlag)
  );

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqReady,
  input logic       seqStart,
  input logic       seqDone,
  input logic       seqErr,
  input logic [2:0] curState,
  input logic       errFlag
);

  function automatic logic hopOk(logic [2:0] a, logic [2:0] b);
    case ({a, b})
      6'o02, 6'o23, 6'o32, 6'o25, 6'o52, 6'o21, 6'o12, 6'o34, 6'o43: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |=> !seqStart); // R5

  AST_BUSY_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |-> !reqReady); // R7

  AST_COMMIT_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curState) |-> ($past(seqDone) && !$past(seqErr))); // R6

  AST_LEGAL_HOP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curState) |-> hopOk($past(curState), curState)); // R3

  AST_NO_RETURN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curState) != 3'd0) |-> (curState != 3'd0)); // R1

  AST_FAIL_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (seqErr && !reqReady && !seqStart) |=> (errFlag && reqReady)); // R9

  AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (seqErr && !reqReady && !seqStart) |=> $stable(curState)); // R12

endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .seqStart (seqStart),
  .seqDone  (seqDone),
  .seqErr   (seqErr),
  .curState (curState),
  .errFlag  (errFlag)
);

// File: tb/test_pwr_state_ctrl.sv
`timescale 1ns/1ps
module test_pwr_state_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqTarget = 3'd0;
  logic       reqReady;
  logic       seqStart;
  logic [3:0] seqCode;
  logic       seqDone = 1'b0;
  logic       seqErr = 1'b0;
  logic [2:0] curState;
  logic       errFlag;

  int nChecks = 0;
  int nFail = 0;
  int mState = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pwr_state_ctrl i_pwr_state_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTarget(reqTarget),
    .reqReady(reqReady), .seqStart(seqStart), .seqCode(seqCode),
    .seqDone(seqDone), .seqErr(seqErr), .curState(curState), .errFlag(errFlag)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected model, derived from the requirements
  function automatic int bHop(int c, int t);
    if (c == 4) return 3;
    if (c == 3) return (t == 4) ? 4 : 2;
    if (c == 2) return (t == 3 || t == 4) ? 3 : t;
    return 2;
  endfunction

  function automatic bit bLegal(int c, int t);
    return (t >= 1) && (t <= 5) && (t != c) && (c != 0 || t == 2);
  endfunction

  function automatic int bCode(int a, int b);
    case (a * 8 + b)
      2:  return 0;  // off->emu
      19: return 1;  // emu->active
      26: return 2;  // active->emu
      21: return 3;  // emu->suspend
      42: return 4;  // suspend->emu
      17: return 5;  // emu->down
      10: return 6;  // down->emu
      28: return 7;  // active->low
      35: return 8;  // low->active
      default: return 15;
    endcase
  endfunction

  // errAt: hop index that fails (-1 none); both: done and err together
  task automatic doReq(int tgt, int errAt, int lat, bit poke, bit stray, bit both);
    int c;
    int step;
    @(negedge clk);
    chk(reqReady == 1'b1, "R7 idle ready", reqReady, 1);
    reqValid = 1'b1;
    reqTarget = 3'(tgt);
    @(negedge clk);
    reqValid = 1'b0;
    if (!bLegal(mState, tgt)) begin
      chk(errFlag == 1'b1, (mState == 0) ? "R2 reject err" : "R8 reject err", errFlag, 1);
      chk(seqStart == 1'b0, "R8 no start", seqStart, 0);
      chk(int'(curState) == mState, "R8 state kept", curState, mState);
      chk(reqReady == 1'b1, "R8 ready kept", reqReady, 1);
      return;
    end
    c = mState;
    step = 0;
    while (c != tgt) begin
      int h;
      h = bHop(c, tgt);
      chk(seqStart == 1'b1, "R5 start", seqStart, 1);
      chk(int'(seqCode) == bCode(c, h), (step == 0) ? "R3 code" : "R4 chain code", seqCode, bCode(c, h));
      chk(reqReady == 1'b0, "R7 busy", reqReady, 0);
      chk(errFlag == 1'b0, "R10 cleared", errFlag, 0);
      if (stray && step == 0) seqDone = 1'b1;
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        seqDone = 1'b0;
        reqValid = poke && (k == 0);
        reqTarget = 3'd1;
        chk(seqStart == 1'b0, "R5 pulse", seqStart, 0);
        chk(int'(curState) == c, stray ? "R11 stray done" : "R6 hold", curState, c);
        chk(reqReady == 1'b0, "R7 busy wait", reqReady, 0);
      end
      reqValid = 1'b0;
      if (step == errAt) begin
        seqErr = 1'b1;
        seqDone = both;
      end else begin
        seqDone = 1'b1;
      end
      @(negedge clk);
      seqDone = 1'b0;
      seqErr = 1'b0;
      if (step == errAt) begin
        chk(int'(curState) == c, both ? "R12 err wins" : "R9 state kept", curState, c);
        chk(errFlag == 1'b1, "R9 err flag", errFlag, 1);
        chk(reqReady == 1'b1, "R9 ready back", reqReady, 1);
        chk(seqStart == 1'b0, "R9 chain stop", seqStart, 0);
        mState = c;
        return;
      end
      chk(int'(curState) == h, "R6 commit", curState, h);
      c = h;
      step++;
    end
    chk(reqReady == 1'b1, "R7 ready at end", reqReady, 1);
    chk(errFlag == 1'b0, "R10 clean end", errFlag, 0);
    mState = tgt;
  endtask

  task automatic goTo(int s);
    if (mState != s) doReq(s, -1, 1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(curState == 3'd0, "R1 reset state", curState, 0);
    chk(reqReady == 1'b1, "R1 reset ready", reqReady, 1);
    chk(seqStart == 1'b0, "R1 reset start", seqStart, 0);
    chk(errFlag == 1'b0, "R1 reset err", errFlag, 0);
    rstN = 1'b1;

    // R2: from power-off only card emulation is accepted
    for (int t = 0; t < 8; t++) if (t != 2) doReq(t, -1, 1, 1'b0, 1'b0, 1'b0);
    doReq(2, -1, 2, 1'b0, 1'b0, 1'b0);

    // R11: done while idle
    @(negedge clk);
    seqDone = 1'b1;
    @(negedge clk);
    seqDone = 1'b0;
    chk(curState == 3'd2, "R11 idle done", curState, 2);
    chk(seqStart == 1'b0, "R11 idle no start", seqStart, 0);

    // sweep every start state against every target code
    for (int s = 1; s <= 5; s++) begin
      for (int t = 0; t < 8; t++) begin
        goTo(s);
        doReq(t, -1, 1 + (t % 3), t == 3, t == 5, 1'b0);
      end
    end

    // R9/R10: error at each hop of low->down
    for (int e = 0; e < 3; e++) begin
      goTo(4);
      doReq(1, e, 1 + e, 1'b0, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      chk(errFlag == 1'b1, "R10 err held", errFlag, 1);
      chk(int'(curState) == mState, "R9 state after fail", curState, mState);
    end
    // R12: done and error together
    goTo(3);
    doReq(5, 1, 2, 1'b0, 1'b0, 1'b1);
    goTo(5);
    doReq(4, -1, 1, 1'b1, 1'b0, 1'b0);
    chk(curState == 3'd4, "R4 suspend to low", curState, 4);
    chk(curState != 3'd0, "R1 never off", curState, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule